// File: doc/BRIEF.md
# Reset and Boot-Load Sequencer

This block carries a processor core from master reset to its first instruction fetch. It tells two kinds of reset apart. A power-on reset arrives on the asynchronous `rst_ni` pin and must wait for the on-chip clock multiplier to lock. That wait is counted in input-clock periods, and one input-clock period is two instruction cycles of `clk_i`. A warm reset arrives on `reset_i` while the clock is already running, so it needs no stabilization wait. While the core is held in reset, the block drives clear strobes for the stack pointers and the status register, and it masks every interrupt.

When reset is released, the sequencer first lets any pending external bus request finish. It then reads the memory-map strap. With the strap low, it runs a boot-load handshake with an external loader. With the strap high, it skips booting. In both cases it ends by issuing a single fetch strobe at the reset vector, address zero. A separate enable flop gives the clock-output buffer its enable, which is the inverse of a disable control bit.

Top module: `reset_boot_seq`

## Requirements
- R1: After `rst_ni` rises, `core_rst_o` stays high for exactly 2*LOCK_CYCLES+3 rising edges of `clk_i`, with `reset_i` low. The count is two release-synchronizer stages, LOCK_CYCLES input-clock periods of two edges each, and one transfer edge. The default LOCK_CYCLES is 2000.
- R2: A warm reset has no lock wait. While the block holds on `reset_i`, the first rising edge that samples `reset_i` low drops `core_rst_o`.
- R3: While `core_rst_o` is high, `stack_clr_o`, `stat_clr_o` and `irq_mask_o` are all 1, and `boot_req_o`, `fetch_o` and `bus_grant_o` are all 0.
- R4: If `bus_req_i` is high on the release edge, `bus_grant_o` goes high and stays high while `bus_req_i` stays high. The edge that samples `bus_req_i` low moves the block on to the boot decision.
- R5: If `map_strap_i` = 0 at the decision edge, `boot_req_o` is held at 1 until an edge samples `boot_done_i` = 1. That edge enters the run state.
- R6: If `map_strap_i` = 1 at the decision edge, booting is skipped and the block enters the run state on that edge.
- R7: On the first cycle of the run state, `fetch_o` is 1 for exactly one cycle, with `fetch_addr_o` = 0. In that same cycle `irq_mask_o` becomes 0.
- R8: If `reset_i` is sampled high while the block is in bus-wait, boot or run, `core_rst_o` is 1 after that edge. This holds even when `boot_done_i` is sampled high on the same edge, and in that case no fetch occurs.
- R9: `rst_ni` low forces `core_rst_o` to 1 at once, from any state. The next release repeats the full R1 wait.
- R10: `clkout_en_o` is 1 during power-on reset. After that, it equals the inverse of the `clkout_off_i` value sampled at the previous edge. A warm reset does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-rate clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| reset_i | input | 1 | Synchronous active-high warm reset request |
| bus_req_i | input | 1 | External bus request |
| map_strap_i | input | 1 | Memory-map strap: 0 boot-loads, 1 skips boot |
| boot_done_i | input | 1 | Boot loader reports completion |
| clkout_off_i | input | 1 | Clock-output disable control bit |
| core_rst_o | output | 1 | Holds the core in reset |
| stack_clr_o | output | 1 | Clears stack pointers to empty |
| stat_clr_o | output | 1 | Clears the status register |
| irq_mask_o | output | 1 | Masks all interrupts |
| bus_grant_o | output | 1 | Bus granted to the external requester |
| boot_req_o | output | 1 | Boot-load request (level) |
| fetch_o | output | 1 | One-cycle first-fetch strobe |
| fetch_addr_o | output | PM_AW | First fetch address (reset vector) |
| clkout_en_o | output | 1 | Clock-output enable |

## Verification
The sharpest collision is a warm reset that arrives on the same edge as the boot loader's completion. The bench drives `reset_i` and `boot_done_i` together while the block is in the boot state. It expects reset to win: `core_rst_o` must rise, and `fetch_o` must never pulse. A second overlap is a bus request that is already pending on the release edge. For that case the bench sweeps both strap values and two request lengths, and checks each time that the boot decision waits for the edge on which the request drops.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [2:0] {
    ST_COLD = 3'd0,
    ST_HOLD = 3'd1,
    ST_BUSW = 3'd2,
    ST_BOOT = 3'd3,
    ST_RUN  = 3'd4
  } rbs_state_e;
endpackage

// File: rtl/rbs_rst_sync.sv
module rbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rbs_lock_cnt.sv
module rbs_lock_cnt #(
  parameter int LOCK_CYCLES = 2000,
  parameter int CLK_RATIO   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam int PH_W  = (CLK_RATIO > 1) ? $clog2(CLK_RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LOCK_CYCLES);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_RATIO - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             tick, cnt_en, ph_en;

  // One input-clock period elapses every CLK_RATIO instruction cycles.
  assign tick = (ph_q == PH_LAST);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    ph_en  = 1'b0;
    cnt_en = 1'b0;
    if (!run_i) begin
      ph_d   = '0;
      cnt_d  = '0;
      ph_en  = (ph_q != '0);
      cnt_en = (cnt_q != '0);
    end else begin
      ph_en = 1'b1;
      ph_d  = tick ? '0 : ph_q + 1'b1;
      if (tick && !done_o) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Saturates: no increment once the limit is reached.
  assign done_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rbs_fsm.sv
module rbs_fsm
  import rbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_done_i,
  input  logic       reset_i,
  input  logic       bus_req_i,
  input  logic       map_strap_i,
  input  logic       boot_done_i,
  output logic       cold_o,
  output logic       core_rst_o,
  output logic       stack_clr_o,
  output logic       stat_clr_o,
  output logic       irq_mask_o,
  output logic       bus_grant_o,
  output logic       boot_req_o,
  output logic       fetch_o
);
  rbs_state_e state_q, state_d;
  logic       fetched_q, fetched_d, fetched_en;
  rbs_state_e after_bus;

  assign after_bus = map_strap_i ? ST_RUN : ST_BOOT;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLD: if (lock_done_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (!reset_i) state_d = bus_req_i ? ST_BUSW : after_bus;
      end
      ST_BUSW: begin
        if (reset_i)         state_d = ST_HOLD;
        else if (!bus_req_i) state_d = after_bus;
      end
      ST_BOOT: begin
        if (reset_i)          state_d = ST_HOLD;
        else if (boot_done_i) state_d = ST_RUN;
      end
      ST_RUN:  if (reset_i) state_d = ST_HOLD;
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_COLD;
    else         state_q <= state_d;
  end

  // Marks that the first fetch of this run period has been issued.
  always_comb begin
    fetched_d  = (state_q == ST_RUN);
    fetched_en = (fetched_d != fetched_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fetched_q <= 1'b0;
    else if (fetched_en) fetched_q <= fetched_d;
  end

  always_comb begin
    cold_o      = (state_q == ST_COLD);
    core_rst_o  = (state_q == ST_COLD) || (state_q == ST_HOLD);
    stack_clr_o = core_rst_o;
    stat_clr_o  = core_rst_o;
    irq_mask_o  = (state_q != ST_RUN);
    bus_grant_o = (state_q == ST_BUSW);
    boot_req_o  = (state_q == ST_BOOT);
    fetch_o     = (state_q == ST_RUN) && !fetched_q;
  end
endmodule

// File: rtl/rbs_clkout.sv
module rbs_clkout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic off_i,
  output logic en_o
);
  logic en_d, en_ce;

  always_comb begin
    en_d  = !off_i;
    en_ce = (en_d != en_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_o <= 1'b1;
    else if (en_ce) en_o <= en_d;
  end
endmodule

// File: rtl/reset_boot_seq.sv
module reset_boot_seq #(
  parameter int                  LOCK_CYCLES = 2000,
  parameter int                  CLK_RATIO   = 2,
  parameter int                  SYNC_STAGES = 2,
  parameter int                  PM_AW       = 14,
  parameter logic [PM_AW-1:0]    RESET_VEC   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_i,
  input  logic             bus_req_i,
  input  logic             map_strap_i,
  input  logic             boot_done_i,
  input  logic             clkout_off_i,
  output logic             core_rst_o,
  output logic             stack_clr_o,
  output logic             stat_clr_o,
  output logic             irq_mask_o,
  output logic             bus_grant_o,
  output logic             boot_req_o,
  output logic             fetch_o,
  output logic [PM_AW-1:0] fetch_addr_o,
  output logic             clkout_en_o
);
  logic rst_n_sync;
  logic lock_done;
  logic cold;

  rbs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  rbs_lock_cnt #(.LOCK_CYCLES(LOCK_CYCLES), .CLK_RATIO(CLK_RATIO)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .run_i  (cold),
    .done_o (lock_done)
  );

  rbs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_sync),
    .lock_done_i (lock_done),
    .reset_i     (reset_i),
    .bus_req_i   (bus_req_i),
    .map_strap_i (map_strap_i),
    .boot_done_i (boot_done_i),
    .cold_o      (cold),
    .core_rst_o  (core_rst_o),
    .stack_clr_o (stack_clr_o),
    .stat_clr_o  (stat_clr_o),
    .irq_mask_o  (irq_mask_o),
    .bus_grant_o (bus_grant_o),
    .boot_req_o  (boot_req_o),
    .fetch_o     (fetch_o)
  );

  rbs_clkout u_clkout (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .off_i  (clkout_off_i),
    .en_o   (clkout_en_o)
  );

  assign fetch_addr_o = RESET_VEC;
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker (
  input logic clk_i,
  input logic rst_n,
  input logic reset_i,
  input logic bus_req_i,
  input logic clkout_off_i,
  input logic core_rst_o,
  input logic stack_clr_o,
  input logic stat_clr_o,
  input logic irq_mask_o,
  input logic bus_grant_o,
  input logic boot_req_o,
  input logic fetch_o,
  input logic clkout_en_o
);
  a_r3_clear_in_reset: assert property (@(posedge clk_i) disable iff (!rst_n)
    core_rst_o |-> (stack_clr_o && stat_clr_o && irq_mask_o && !fetch_o
                    && !boot_req_o && !bus_grant_o));

  a_r7_fetch_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    fetch_o |=> !fetch_o);

  a_r7_unmask_on_fetch: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_mask_o) |-> fetch_o);

  a_r8_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reset_i && !core_rst_o) |=> core_rst_o);

  a_r4_grant_holds: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_grant_o && bus_req_i && !reset_i) |=> bus_grant_o);

  a_r10_clkout_follow: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(rst_n) |-> (clkout_en_o == !$past(clkout_off_i)));
endmodule

bind reset_boot_seq rbs_checker u_rbs_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_sync),
  .reset_i      (reset_i),
  .bus_req_i    (bus_req_i),
  .clkout_off_i (clkout_off_i),
  .core_rst_o   (core_rst_o),
  .stack_clr_o  (stack_clr_o),
  .stat_clr_o   (stat_clr_o),
  .irq_mask_o   (irq_mask_o),
  .bus_grant_o  (bus_grant_o),
  .boot_req_o   (boot_req_o),
  .fetch_o      (fetch_o),
  .clkout_en_o  (clkout_en_o)
);

// File: tb/reset_boot_seq_tb.sv
module reset_boot_seq_tb;
  localparam int LOCK    = 2000;
  localparam int PM_AW   = 14;
  localparam int COLD_EXP = 2 * LOCK + 3;

  logic clk = 1'b0;
  logic rst_ni, reset_i, bus_req_i, map_strap_i, boot_done_i, clkout_off_i;
  logic core_rst_o, stack_clr_o, stat_clr_o, irq_mask_o;
  logic bus_grant_o, boot_req_o, fetch_o, clkout_en_o;
  logic [PM_AW-1:0] fetch_addr_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  reset_boot_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .reset_i      (reset_i),
    .bus_req_i    (bus_req_i),
    .map_strap_i  (map_strap_i),
    .boot_done_i  (boot_done_i),
    .clkout_off_i (clkout_off_i),
    .core_rst_o   (core_rst_o),
    .stack_clr_o  (stack_clr_o),
    .stat_clr_o   (stat_clr_o),
    .irq_mask_o   (irq_mask_o),
    .bus_grant_o  (bus_grant_o),
    .boot_req_o   (boot_req_o),
    .fetch_o      (fetch_o),
    .fetch_addr_o (fetch_addr_o),
    .clkout_en_o  (clkout_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // R3 reset outputs as one packed word: {core, stk, stat, mask, grant, boot, fetch}
  function automatic logic [6:0] rst_word();
    return {core_rst_o, stack_clr_o, stat_clr_o, irq_mask_o, bus_grant_o, boot_req_o, fetch_o};
  endfunction

  task automatic cold_count(input string req);
    int n = 0;
    rst_ni = 1'b1;
    @(negedge clk);
    while (core_rst_o && n < 3 * COLD_EXP) begin
      if (rst_word() !== 7'b1111000) chk("R3 during cold wait", rst_word(), 7'b1111000);
      n++;
      @(negedge clk);
    end
    chk(req, n, COLD_EXP);
  endtask

  // Completes from boot state: done pulse, then fetch check.
  task automatic finish_boot();
    repeat (2) begin
      chk("R5 boot_req held", boot_req_o, 1);
      @(negedge clk);
    end
    boot_done_i = 1'b1;
    @(negedge clk);
    boot_done_i = 1'b0;
    chk("R7 fetch strobe", fetch_o, 1);
    chk("R7 fetch addr zero", fetch_addr_o, 0);
    chk("R7 irq unmasked", irq_mask_o, 0);
    @(negedge clk);
    chk("R7 fetch single", fetch_o, 0);
  endtask

  task automatic warm_seq(input logic strap, input logic busreq, input int blen);
    reset_i = 1'b1;
    @(negedge clk);
    chk("R8 warm reset enters hold", core_rst_o, 1);
    chk("R3 clears in hold", rst_word(), 7'b1111000);
    map_strap_i = strap;
    bus_req_i   = busreq;
    repeat (2) @(negedge clk);
    reset_i = 1'b0;
    @(negedge clk);
    chk("R2 warm release immediate", core_rst_o, 0);
    if (busreq) begin
      for (int i = 0; i < blen; i++) begin
        chk("R4 bus grant held", bus_grant_o, 1);
        chk("R4 no boot in bus wait", boot_req_o, 0);
        if (i != blen - 1) @(negedge clk);
      end
      bus_req_i = 1'b0;
      @(negedge clk);
      chk("R4 grant drops", bus_grant_o, 0);
    end
    if (strap) begin
      chk("R6 skip boot", boot_req_o, 0);
      chk("R6 fetch direct", fetch_o, 1);
      @(negedge clk);
      chk("R7 fetch single", fetch_o, 0);
    end else begin
      finish_boot();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; reset_i = 1'b0; bus_req_i = 1'b0; map_strap_i = 1'b0;
    boot_done_i = 1'b0; clkout_off_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset state", rst_word(), 7'b1111000);
    chk("R10 clkout enabled in reset", clkout_en_o, 1);

    cold_count("R1 cold lock wait");
    chk("R5 boot entered", boot_req_o, 1);
    finish_boot();

    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 2; b++)
        for (int l = 1; l <= 3; l += 2)
          warm_seq(s[0], b[0], l);

    // R8 race: reset and boot completion on the same edge.
    warm_seq(1'b0, 1'b0, 1);
    reset_i = 1'b1; map_strap_i = 1'b0;
    @(negedge clk);
    reset_i = 1'b0;
    @(negedge clk);
    chk("R5 boot before race", boot_req_o, 1);
    reset_i = 1'b1; boot_done_i = 1'b1;
    @(negedge clk);
    boot_done_i = 1'b0;
    chk("R8 reset beats boot_done", core_rst_o, 1);
    chk("R8 no fetch on race", fetch_o, 0);
    @(negedge clk);
    chk("R8 still no fetch", fetch_o, 0);
    reset_i = 1'b0;
    @(negedge clk);
    chk("R8 back to boot", boot_req_o, 1);
    finish_boot();

    // R10 clock-output enable
    clkout_off_i = 1'b1;
    @(negedge clk);
    chk("R10 clkout disabled", clkout_en_o, 0);
    reset_i = 1'b1;
    @(negedge clk);
    chk("R10 warm reset keeps disable", clkout_en_o, 0);
    reset_i = 1'b0;
    clkout_off_i = 1'b0;
    @(negedge clk);
    chk("R10 clkout re-enabled", clkout_en_o, 1);
    map_strap_i = 1'b1;

    // R9 power-on reset re-entry from run
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R9 async cold entry", core_rst_o, 1);
    @(negedge clk);
    cold_count("R9 full wait repeated");
    chk("R6 fetch after cold", fetch_o, 1);

    summary();
    $finish;
  end
endmodule